// File: doc/BRIEF.md
# Calendar Alarm Match and Interrupt

This block holds a four-field calendar alarm (seconds, minutes, hours, day of month) and compares it with the current time each time the timekeeper issues its one-cycle seconds tick. All values are in BCD. The top bit of each alarm byte is one bit of a four-bit repeat code. That code chooses which fields must match, from every second up to once a month. When a match occurs, an alarm flag is set. An active-low interrupt follows the flag when the flag enable is on.

Software reaches the block through a latched address with separate read and write strobes. A read of the flags byte clears the flag and releases the interrupt. A match that occurs while the flags address is latched is held back until the address moves elsewhere, so a flag read cannot hide a new alarm. In backup mode a second enable gates the interrupt. A power-up reset clears both enables but keeps the alarm settings and the flag, so boot code can see an alarm that occurred while the system was down. The interrupt is driven as a low level together with an output enable, so the top level can model an open-drain pad.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The alarm bytes live at 0x1FF2 (seconds), 0x1FF3 (minutes), 0x1FF4 (hours) and 0x1FF5 (date). A write stores the whole byte, and a read returns it on rdata_o while rd_i is high. Bits 6:0 are the BCD field for seconds and minutes, and bits 5:0 for hours and date.
- R2: The control byte at 0x1FF6 holds the flag enable in bit 7 and the backup enable in bit 6. It reads back as written, with all other bits zero.
- R3: The repeat code is {date[7], hour[7], min[7], sec[7]}. Code 1111 fires every tick. Code 1110 compares seconds. Code 1100 compares seconds and minutes. Code 1000 compares seconds, minutes and hours. Code 0000 compares all four fields.
- R4: Every other repeat code fires on every tick.
- R5: A tick with a match while the latched address is not 0x1FF0 sets the flag, read as bit 6 of 0x1FF0, at that clock edge. Outside backup mode, irq_no is low exactly when the flag and the flag enable are both set.
- R6: A read of 0x1FF0 clears the flag and releases irq_no at the next edge. A write to 0x1FF0 has no effect.
- R7: A match that occurs while 0x1FF0 is latched does not set the flag. The flag is set at the first edge after a different address is latched.
- R8: While backup_i is high, irq_no asserts only if the backup enable is also set. The flag is set either way.
- R9: rst_ni clears both enables. It leaves the alarm bytes and the flag unchanged.
- R10: Code 0000 with a zero date field never fires.
- R11: irq_oe_o is high exactly when irq_no is low.
- R12: Without tick_i the flag does not change, even when the time matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| addr_i | input | 13 | Latched register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when rd_i is low |
| tick_i | input | 1 | One-cycle seconds tick |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hour_i | input | 8 | Current hours, BCD |
| date_i | input | 8 | Current day of month, BCD |
| backup_i | input | 1 | Battery-backup indication |
| irq_no | output | 1 | Active-low interrupt level |
| irq_oe_o | output | 1 | Interrupt drive enable |

## Verification
The assertions assume that rd_i and wr_i are never both high. They also assume that tick_i is a single-cycle pulse with the time fields steady around it, and that addr_i changes only on the falling clock edge. The bench drives every strobe, address and time field on the falling edge and raises the tick for exactly one cycle. It never issues a read and a write together, so the flag and pending-state properties only see input sequences the block is specified for.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NFIELD = 4;
  localparam int FW = 8;
  typedef logic [NFIELD-1:0][FW-1:0] fields_t;
  // index 0 sec, 1 min, 2 hour, 3 date
  localparam fields_t FIELD_MASK = {8'h3F, 8'h3F, 8'h7F, 8'h7F};

  // repeat code -> compare enable per field
  function automatic logic [NFIELD-1:0] rpt_cmp_en(input logic [NFIELD-1:0] rpt);
    case (rpt)
      4'b1110: return 4'b0001;
      4'b1100: return 4'b0011;
      4'b1000: return 4'b0111;
      4'b0000: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs import rtc_alarm_pkg::*; #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
  parameter logic [ADDR_W-1:0] ALM_BASE  = 13'h1FF2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h1FF6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [FW-1:0]     wdata_i,
  input  logic              af_i,
  output logic [FW-1:0]     rdata_o,
  output fields_t           alm_o,
  output logic              afe_o,
  output logic              abe_o
);
  localparam int AF_BIT = 6;
  localparam int AFE_BIT = 7;
  localparam int ABE_BIT = 6;

  fields_t alm_q;
  logic    afe_q, abe_q;

  // alarm bytes are battery-backed: not cleared by power-up reset
  for (genvar i = 0; i < NFIELD; i++) begin : g_alm
    logic we;
    assign we = wr_i && (addr_i == ALM_BASE + ADDR_W'(i));
    always_ff @(posedge clk_i) begin
      if (we) alm_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      afe_q <= 1'b0;
      abe_q <= 1'b0;
    end else if (wr_i && addr_i == CTRL_ADDR) begin
      afe_q <= wdata_i[AFE_BIT];
      abe_q <= wdata_i[ABE_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == FLAG_ADDR) rdata_o[AF_BIT] = af_i;
      else if (addr_i == CTRL_ADDR) begin
        rdata_o[AFE_BIT] = afe_q;
        rdata_o[ABE_BIT] = abe_q;
      end else begin
        for (int i = 0; i < NFIELD; i++)
          if (addr_i == ALM_BASE + ADDR_W'(i)) rdata_o = alm_q[i];
      end
    end
  end

  assign alm_o = alm_q;
  assign afe_o = afe_q;
  assign abe_o = abe_q;

  assert_ctrl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == CTRL_ADDR) |=> (afe_q == $past(wdata_i[AFE_BIT])));
endmodule

// File: rtl/alarm_match.sv
module alarm_match import rtc_alarm_pkg::*; (
  input  fields_t alm_i,
  input  fields_t now_i,
  input  logic    tick_i,
  output logic    hit_o
);
  logic [NFIELD-1:0] rpt, eq, en;
  logic              off;

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign rpt[i] = alm_i[i][FW-1];
    assign eq[i]  = ((alm_i[i] ^ now_i[i]) & FIELD_MASK[i]) == '0;
  end

  assign en    = rpt_cmp_en(rpt);
  assign off   = (rpt == '0) && ((alm_i[NFIELD-1] & FIELD_MASK[NFIELD-1]) == '0);
  assign hit_o = tick_i && !off && (&(eq | ~en));

  always_comb begin
    if (!tick_i) assert_no_hit_without_tick_R12: assert (!hit_o);
  end
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic flags_sel_i,
  input  logic rd_i,
  input  logic afe_i,
  input  logic abe_i,
  input  logic backup_i,
  output logic af_o,
  output logic irq_o
);
  logic af_q, pend_q;

  // flag is battery-backed; only the pending state is reset
  always_ff @(posedge clk_i) begin
    if (flags_sel_i) begin
      if (rd_i) af_q <= 1'b0;
    end else if (hit_i || pend_q) begin
      af_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pend_q <= 1'b0;
    else if (flags_sel_i && hit_i)    pend_q <= 1'b1;
    else if (!flags_sel_i)            pend_q <= 1'b0;
  end

  assign af_o  = af_q;
  assign irq_o = af_q && afe_i && (!backup_i || abe_i);

  assert_hit_sets_af_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !flags_sel_i) |=> af_q);
  assert_read_clears_af_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && flags_sel_i) |=> !af_q);
  assert_no_set_while_latched_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_sel_i |=> !$rose(af_q));
  assert_pending_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !flags_sel_i) |=> (af_q && !pend_q));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq import rtc_alarm_pkg::*; #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
  parameter logic [ADDR_W-1:0] ALM_BASE  = 13'h1FF2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h1FF6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_i,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  input  logic [7:0]        date_i,
  input  logic              backup_i,
  output logic              irq_no,
  output logic              irq_oe_o
);
  fields_t alm, now;
  logic    afe, abe, af, hit, irq, flags_sel;

  assign now       = {date_i, hour_i, min_i, sec_i};
  assign flags_sel = (addr_i == FLAG_ADDR);

  alarm_regs #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .ALM_BASE(ALM_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .wdata_i,
    .af_i(af), .rdata_o, .alm_o(alm), .afe_o(afe), .abe_o(abe)
  );

  alarm_match u_match (.alm_i(alm), .now_i(now), .tick_i, .hit_o(hit));

  alarm_flag u_flag (
    .clk_i, .rst_ni, .hit_i(hit), .flags_sel_i(flags_sel), .rd_i,
    .afe_i(afe), .abe_i(abe), .backup_i, .af_o(af), .irq_o(irq)
  );

  assign irq_no   = ~irq;
  assign irq_oe_o = irq;

  assert_backup_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backup_i && !abe) |-> !irq_oe_o);
  assert_afe_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !afe |-> irq_no);
  assert_oe_polarity_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o != irq_no);
endmodule

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb;
  localparam logic [12:0] A_FLAG = 13'h1FF0, A_ALM = 13'h1FF2, A_CTRL = 13'h1FF6;
  localparam logic [7:0] AS = 8'h30, AM = 8'h15, AH = 8'h08, AD = 8'h12;

  logic clk = 0, rst_n = 0;
  logic [12:0] addr = 0;
  logic rd = 0, wr = 0, tick = 0, backup = 0;
  logic [7:0] wdata = 0, rdata, sec = 0, min = 0, hour = 0, date = 0;
  logic irq_n, irq_oe;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  rtc_alarm_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .sec_i(sec), .min_i(min),
    .hour_i(hour), .date_i(date), .backup_i(backup), .irq_no(irq_n), .irq_oe_o(irq_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0; addr = 0;
  endtask

  task automatic rd_reg(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0; addr = 0;
  endtask

  task automatic clear_af();
    logic [7:0] d;
    rd_reg(A_FLAG, d);
  endtask

  task automatic set_alarm(input logic [3:0] code, input logic [7:0] s, m, h, dt);
    wr_reg(A_ALM,     {code[0], s[6:0]});
    wr_reg(A_ALM + 1, {code[1], m[6:0]});
    wr_reg(A_ALM + 2, {code[2], h[6:0]});
    wr_reg(A_ALM + 3, {code[3], dt[6:0]});
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  function automatic bit model_fire(input logic [3:0] code, input logic [7:0] s, m, h, dt,
                                    input logic [7:0] ts, tm, th, td);
    bit es, em, eh, ed;
    es = (s & 8'h7F) == (ts & 8'h7F);
    em = (m & 8'h7F) == (tm & 8'h7F);
    eh = (h & 8'h3F) == (th & 8'h3F);
    ed = (dt & 8'h3F) == (td & 8'h3F);
    case (code)
      4'b1110: return es;
      4'b1100: return es && em;
      4'b1000: return es && em && eh;
      4'b0000: return ((dt & 8'h3F) != 0) && es && em && eh && ed;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit exp;
    repeat (3) @(negedge clk);
    // reset state, R9 / R11
    check(irq_n == 1 && irq_oe == 0, "R11 reset irq idle", irq_n, 1);
    rst_n = 1;
    rd_reg(A_CTRL, d);
    check(d == 8'h00, "R9 enables clear after reset", d, 0);

    // R1 / R2 readback
    wr_reg(A_ALM + 1, 8'hA7);
    rd_reg(A_ALM + 1, d);
    check(d == 8'hA7, "R1 alarm byte readback", d, 8'hA7);
    wr_reg(A_CTRL, 8'hC0);
    rd_reg(A_CTRL, d);
    check(d == 8'hC0, "R2 ctrl readback", d, 8'hC0);
    wr_reg(A_CTRL, 8'h80);
    rd_reg(A_CTRL, d);
    check(d == 8'h80, "R2 ctrl readback afe only", d, 8'h80);

    // sweep: all 16 repeat codes x 5 time patterns (R3, R4, R5)
    for (int c = 0; c < 16; c++) begin
      for (int v = 0; v < 5; v++) begin
        logic [7:0] ts, tm, th, td;
        ts = AS; tm = AM; th = AH; td = AD;
        if (v == 1) ts = 8'h31;
        if (v == 2) tm = 8'h16;
        if (v == 3) th = 8'h09;
        if (v == 4) td = 8'h13;
        set_alarm(4'(c), AS, AM, AH, AD);
        clear_af();
        @(negedge clk); sec = ts; min = tm; hour = th; date = td;
        exp = model_fire(4'(c), AS, AM, AH, AD, ts, tm, th, td);
        pulse_tick();
        check(irq_n == !exp, (c inside {15, 14, 12, 8, 0}) ? "R3 irq vs mode" : "R4 irq invalid code",
              irq_n, !exp);
        rd_reg(A_FLAG, d);
        check(d[6] == exp, "R5 flag bit vs mode", d[6], exp);
      end
    end

    // R10 disable with zero date and repeat bits
    set_alarm(4'b0000, 8'h00, 8'h00, 8'h00, 8'h00);
    clear_af();
    @(negedge clk); sec = 0; min = 0; hour = 0; date = 0;
    pulse_tick();
    rd_reg(A_FLAG, d);
    check(d[6] == 0, "R10 zero date disables", d[6], 0);

    // R12 no tick, matching time
    set_alarm(4'b0000, AS, AM, AH, AD);
    clear_af();
    @(negedge clk); sec = AS; min = AM; hour = AH; date = AD;
    repeat (4) @(negedge clk);
    check(irq_n == 1, "R12 no tick no irq", irq_n, 1);
    rd_reg(A_FLAG, d);
    check(d[6] == 0, "R12 no tick no flag", d[6], 0);

    // R7 deferral while flags address latched
    set_alarm(4'b1111, AS, AM, AH, AD);
    clear_af();
    @(negedge clk); addr = A_FLAG; tick = 1;
    @(negedge clk); tick = 0;
    check(irq_n == 1, "R7 no set while latched", irq_n, 1);
    @(negedge clk);
    check(irq_n == 1, "R7 still deferred", irq_n, 1);
    addr = 0;
    #1 check(irq_n == 1, "R7 not before edge", irq_n, 1);
    @(negedge clk);
    check(irq_n == 0, "R7 set after address moves", irq_n, 0);
    check(irq_oe == 1, "R11 oe while asserted", irq_oe, 1);

    // R6 write to flags ignored, read clears
    wr_reg(A_FLAG, 8'h00);
    check(irq_n == 0, "R6 flag write ignored", irq_n, 0);
    @(negedge clk); addr = A_FLAG; rd = 1;
    #1 check(rdata[6] == 1, "R6 read shows flag", rdata[6], 1);
    @(negedge clk); rd = 0; addr = 0;
    check(irq_n == 1 && irq_oe == 0, "R6 read releases irq", irq_n, 1);

    // R8 backup gating
    wr_reg(A_CTRL, 8'h80);
    clear_af();
    @(negedge clk); backup = 1;
    pulse_tick();
    check(irq_n == 1, "R8 backup without abe", irq_n, 1);
    @(negedge clk); backup = 0;
    #1 check(irq_n == 0, "R8 flag set during backup", irq_n, 0);
    wr_reg(A_CTRL, 8'hC0);
    clear_af();
    @(negedge clk); backup = 1;
    pulse_tick();
    check(irq_n == 0, "R8 backup with abe", irq_n, 0);
    @(negedge clk); backup = 0;

    // R9 reset keeps alarm and flag, clears enables
    set_alarm(4'b0000, AS, AM, AH, AD);
    wr_reg(A_CTRL, 8'hC0);
    clear_af();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd_reg(A_CTRL, d);
    check(d == 8'h00, "R9 enables cleared", d, 0);
    rd_reg(A_ALM + 3, d);
    check(d == AD, "R9 alarm byte kept", d, AD);
    @(negedge clk); backup = 1; sec = AS; min = AM; hour = AH; date = AD;
    pulse_tick();
    check(irq_n == 1, "R9 alarm at power-up no irq", irq_n, 1);
    @(negedge clk); backup = 0;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd_reg(A_FLAG, d);
    check(d[6] == 1, "R9 flag kept across reset", d[6], 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule